// File: doc/BRIEF.md
# Reseeding PRBS Payload Error Checker

This block is the receive-side bit-error tester for a test pattern whose payload comes from a 2^23-1 pseudo-random generator. The generator restarts at the start of every frame's payload envelope. An upstream overhead processor has already found frame alignment, descrambled the line and removed every overhead and marker byte. It hands the block only payload bytes, with a valid qualifier, a marker on the first payload byte of each frame, and a parity bit telling which of the two seeds that frame uses.

The checker does not synchronise itself from the data. At each envelope start it reloads a local copy of the generator with the indicated seed. That seed is the configured seed when parity is 0 and its bitwise inverse when parity is 1. The checker then compares every later payload byte bit by bit against the local sequence. The forced restart at each frame boundary is part of the pattern and is never counted as an error.

Mismatching bits go into a saturating bit-error counter. Frames that hold at least one bad bit go into a saturating errored-frame counter. A sticky flag shows whether any error has been seen since the last clear. If the parity bit breaks the expected alternation, the checker follows the indicated seed and pulses a slip output for one cycle.

Top module: `prbs_pl_checker`

## Requirements
- R1: After reset both counters read 0, `err_seen` and `align_slip` are 0, and the checker is unlocked.
- R2: A byte is compared only in a cycle with `pl_valid` high, and only once an envelope start has been accepted since reset. Bytes with `pl_valid` low, and valid bytes before the first `spe_start`, change neither the counters nor the local generator.
- R3: The expected sequence follows x^23 + x^18 + 1. Each new bit is state[22] XOR state[17], and it is shifted into state[0]. Eight bits form one byte, and the first bit generated goes in data bit 7. A valid byte with `spe_start` high is checked against a generator freshly loaded with `SEED_A` when `frame_odd` is 0, or with `~SEED_A` when `frame_odd` is 1. The reload itself produces no error.
- R4: `bit_err_cnt` adds the number of 1 bits in (received XOR expected) at the clock edge that takes the byte. It is visible in the next cycle and saturates at 2^CNT_W-1.
- R5: `frm_err_cnt` goes up by 1 on the first errored byte of each frame and no further for that frame. It saturates at 2^CNT_W-1.
- R6: `err_seen` goes high with the first counted error and stays high until a clear.
- R7: `clear` zeroes both counters, `err_seen` and the per-frame error mark at the next edge. It takes priority over an error in the same cycle. It does not disturb generator alignment.
- R8: A valid `spe_start` while locked with `frame_odd` equal to the previous frame's parity raises `align_slip` for exactly the next cycle. The frame is still checked with the seed that `frame_odd` indicates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pl_valid | input | 1 | Payload byte qualifier |
| pl_data | input | DW | Received payload byte |
| spe_start | input | 1 | First payload byte of a frame (meaningful with pl_valid) |
| frame_odd | input | 1 | Seed select for the starting frame: 0 seed, 1 inverted seed |
| clear | input | 1 | Zero counters and sticky flag |
| bit_err_cnt | output | CNT_W | Saturating bit-error count |
| frm_err_cnt | output | CNT_W | Saturating errored-frame count |
| err_seen | output | 1 | Sticky error flag |
| align_slip | output | 1 | One-cycle seed-parity slip pulse |

## Verification
The bench sends alternating-seed frames with random idle gaps. A checker that failed to reseed, or that compared the last byte of one frame against the next, would count errors at every boundary of a clean stream. Single-bit and multi-bit faults, including faults on the first byte of a frame, test the popcount and the once-per-frame rule. A design that counted errored bytes instead of errored frames would drift from the model. The bench also repeats a parity value, sends garbage before lock and in invalid cycles, clears in the same cycle as an error, and drives both counters into saturation. These cover a missing or misplaced slip pulse, a generator that advances on idle cycles, and a counter that wraps instead of holding.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;
    localparam int PRBS_ORDER = 23;
    localparam int PRBS_TAP   = 18;

    function automatic logic [PRBS_ORDER-1:0] pick_seed(
        input logic [PRBS_ORDER-1:0] base,
        input logic                  odd
    );
        return odd ? ~base : base;
    endfunction
endpackage

// File: rtl/prbs_byte_step.sv
module prbs_byte_step #(
    parameter int N   = 23,
    parameter int TAP = 18,
    parameter int DW  = 8
) (
    input  logic [N-1:0]  state_i,
    output logic [DW-1:0] byte_o,
    output logic [N-1:0]  state_o
);
    logic [N-1:0] chain [0:DW];
    logic [DW-1:0] fb;

    assign chain[0] = state_i;

    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign fb[i]         = chain[i][N-1] ^ chain[i][TAP-1];
        assign chain[i+1]    = {chain[i][N-2:0], fb[i]};
        assign byte_o[DW-1-i] = fb[i];
    end

    assign state_o = chain[DW];
endmodule

// File: rtl/err_popcount.sv
module err_popcount #(
    parameter int DW = 8,
    parameter int CW = $clog2(DW + 1)
) (
    input  logic [DW-1:0] bits_i,
    output logic [CW-1:0] count_o
);
    logic [CW-1:0] partial [0:DW];

    assign partial[0] = '0;
    for (genvar i = 0; i < DW; i++) begin : g_sum
        assign partial[i+1] = partial[i] + {{(CW-1){1'b0}}, bits_i[i]};
    end

    assign count_o = partial[DW];
endmodule

// File: rtl/sat_add.sv
module sat_add #(
    parameter int W  = 32,
    parameter int AW = 4
) (
    input  logic [W-1:0]  acc_i,
    input  logic [AW-1:0] inc_i,
    output logic [W-1:0]  sum_o
);
    logic [W:0] wide;

    assign wide  = {1'b0, acc_i} + {{(W+1-AW){1'b0}}, inc_i};
    assign sum_o = wide[W] ? {W{1'b1}} : wide[W-1:0];
endmodule

// File: rtl/prbs_pl_checker.sv
module prbs_pl_checker
    import prbs_chk_pkg::*;
#(
    parameter int                  DW     = 8,
    parameter int                  CNT_W  = 32,
    parameter logic [PRBS_ORDER-1:0] SEED_A = 23'h1A5C3E
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pl_valid,
    input  logic [DW-1:0]    pl_data,
    input  logic             spe_start,
    input  logic             frame_odd,
    input  logic             clear,
    output logic [CNT_W-1:0] bit_err_cnt,
    output logic [CNT_W-1:0] frm_err_cnt,
    output logic             err_seen,
    output logic             align_slip
);
    localparam int N  = PRBS_ORDER;
    localparam int PW = $clog2(DW + 1);

    typedef struct packed {
        logic [N-1:0]     gen;
        logic             locked;
        logic             parity;
        logic             frame_err;
        logic [CNT_W-1:0] bits;
        logic [CNT_W-1:0] frames;
        logic             seen;
        logic             slip;
    } chk_state_t;

    chk_state_t st_d, st_q;

    logic [N-1:0]     gen_src;
    logic [N-1:0]     gen_next;
    logic [DW-1:0]    exp_byte;
    logic [PW-1:0]    mis_bits;
    logic [CNT_W-1:0] bits_sum;
    logic [CNT_W-1:0] frames_sum;
    logic             start_ok;
    logic             cmp_en;
    logic             mark_eff;

    assign start_ok = pl_valid && spe_start;
    assign cmp_en   = pl_valid && (spe_start || st_q.locked);
    assign gen_src  = spe_start ? pick_seed(SEED_A, frame_odd) : st_q.gen;
    assign mark_eff = spe_start ? 1'b0 : st_q.frame_err;

    prbs_byte_step #(.N(N), .TAP(PRBS_TAP), .DW(DW)) u_step (
        .state_i (gen_src),
        .byte_o  (exp_byte),
        .state_o (gen_next)
    );

    err_popcount #(.DW(DW), .CW(PW)) u_pop (
        .bits_i  (pl_data ^ exp_byte),
        .count_o (mis_bits)
    );

    sat_add #(.W(CNT_W), .AW(PW)) u_bit_acc (
        .acc_i (st_q.bits),
        .inc_i (mis_bits),
        .sum_o (bits_sum)
    );

    sat_add #(.W(CNT_W), .AW(1)) u_frm_acc (
        .acc_i (st_q.frames),
        .inc_i (1'b1),
        .sum_o (frames_sum)
    );

    always_comb begin
        st_d      = st_q;
        st_d.slip = 1'b0;

        if (cmp_en) begin
            st_d.gen = gen_next;
        end

        if (start_ok) begin
            st_d.slip      = st_q.locked && (frame_odd == st_q.parity);
            st_d.locked    = 1'b1;
            st_d.parity    = frame_odd;
            st_d.frame_err = 1'b0;
        end

        if (cmp_en && (mis_bits != '0)) begin
            st_d.bits      = bits_sum;
            st_d.frame_err = 1'b1;
            st_d.seen      = 1'b1;
            if (!mark_eff) begin
                st_d.frames = frames_sum;
            end
        end

        if (clear) begin
            st_d.bits      = '0;
            st_d.frames    = '0;
            st_d.seen      = 1'b0;
            st_d.frame_err = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_err_cnt = st_q.bits;
    assign frm_err_cnt = st_q.frames;
    assign err_seen    = st_q.seen;
    assign align_slip  = st_q.slip;
endmodule

// File: rtl/prbs_pl_chk_sva.sv
module prbs_pl_chk_sva #(
    parameter int DW    = 8,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pl_valid,
    input logic             spe_start,
    input logic             clear,
    input logic [CNT_W-1:0] bit_err_cnt,
    input logic [CNT_W-1:0] frm_err_cnt,
    input logic             err_seen,
    input logic             align_slip
);
    // R4
    bits_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> bit_err_cnt >= $past(bit_err_cnt));

    // R5
    frm_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (frm_err_cnt == $past(frm_err_cnt)) ||
                   (frm_err_cnt == $past(frm_err_cnt) + 1'b1));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pl_valid && !clear |=> $stable(bit_err_cnt) && $stable(frm_err_cnt));

    // R6
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_seen && !clear |=> err_seen);

    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> bit_err_cnt == '0 && frm_err_cnt == '0 && !err_seen);

    // R8
    slip_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pl_valid && spe_start) |=> !align_slip);

    // R8
    slip_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        align_slip |=> !align_slip);
endmodule

bind prbs_pl_checker prbs_pl_chk_sva #(.DW(DW), .CNT_W(CNT_W)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .pl_valid    (pl_valid),
    .spe_start   (spe_start),
    .clear       (clear),
    .bit_err_cnt (bit_err_cnt),
    .frm_err_cnt (frm_err_cnt),
    .err_seen    (err_seen),
    .align_slip  (align_slip)
);

// File: tb/prbs_pl_checker_tb.sv
module prbs_pl_checker_tb;
    localparam int CW   = 10;
    localparam int SEED = 'h1A5C3E;
    localparam int MAXC = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pl_valid = 1'b0;
    logic [7:0]    pl_data = '0;
    logic          spe_start = 1'b0;
    logic          frame_odd = 1'b0;
    logic          clear = 1'b0;
    logic [CW-1:0] bit_err_cnt, frm_err_cnt;
    logic          err_seen, align_slip;

    always #2.5 clk = ~clk;

    prbs_pl_checker #(.DW(8), .CNT_W(CW), .SEED_A(23'h1A5C3E)) u_dut (
        .clk(clk), .rst_n(rst_n), .pl_valid(pl_valid), .pl_data(pl_data),
        .spe_start(spe_start), .frame_odd(frame_odd), .clear(clear),
        .bit_err_cnt(bit_err_cnt), .frm_err_cnt(frm_err_cnt),
        .err_seen(err_seen), .align_slip(align_slip)
    );

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;
    string phase_tag = "R1";

    // behavioural reference state
    int m_gen = 0, m_bits = 0, m_frms = 0;
    bit m_lock = 0, m_par = 0, m_mark = 0, m_seen = 0, m_slip = 0;
    int tx_gen = 0;

    function automatic logic [7:0] next_byte(inout int s);
        logic [7:0] r = 0;
        for (int k = 0; k < 8; k++) begin
            int b = ((s >> 22) ^ (s >> 17)) & 1;
            r = {r[6:0], b[0]};
            s = ((s << 1) | b) & 'h7FFFFF;
        end
        return r;
    endfunction

    function automatic int seed_of(bit odd);
        return odd ? (~SEED && 'h7FFFFF) * 0 + ((~SEED) & 'h7FFFFF) : SEED;
    endfunction

    task automatic model_edge();
        bit nslip = 0;
        if (pl_valid && (spe_start || m_lock)) begin
            int s = spe_start ? seed_of(frame_odd) : m_gen;
            logic [7:0] e = next_byte(s);
            int pc = $countones(pl_data ^ e);
            bit mark = spe_start ? 0 : m_mark;
            m_gen = s;
            if (spe_start) begin
                nslip  = m_lock && (frame_odd == m_par);
                m_lock = 1; m_par = frame_odd; m_mark = 0;
            end
            if (pc != 0) begin
                m_bits = (m_bits + pc > MAXC) ? MAXC : m_bits + pc;
                if (!mark) m_frms = (m_frms + 1 > MAXC) ? MAXC : m_frms + 1;
                m_mark = 1; m_seen = 1;
            end
        end
        if (clear) begin
            m_bits = 0; m_frms = 0; m_seen = 0; m_mark = 0;
        end
        m_slip = nslip;
    endtask

    task automatic chk(string tag, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk(phase_tag, "bit_err_cnt", int'(bit_err_cnt), m_bits);
        chk(phase_tag == "R5" ? "R5" : "R4", "frm_err_cnt", int'(frm_err_cnt), m_frms);
        chk("R6", "err_seen", int'(err_seen), int'(m_seen));
        chk("R8", "align_slip", int'(align_slip), int'(m_slip));
    endtask

    // inputs are set before the call, at a falling edge
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
        pl_valid = 0; spe_start = 0; clear = 0;
        pl_data = 8'($urandom); frame_odd = 1'($urandom);
    endtask

    task automatic idle_gaps();
        int g = $urandom_range(0, 2);
        for (int i = 0; i < g; i++) step();
    endtask

    task automatic send_frame(int len, bit par, int epos, logic [7:0] emask,
                              logic [7:0] all_mask, int clr_at);
        for (int i = 0; i < len; i++) begin
            logic [7:0] b;
            idle_gaps();
            if (i == 0) tx_gen = seed_of(par);
            b = next_byte(tx_gen);
            pl_valid  = 1;
            spe_start = (i == 0);
            frame_odd = par;
            pl_data   = b ^ all_mask ^ ((i == epos) ? emask : 8'h00);
            clear     = (i == clr_at);
            step();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            misses++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: state just after reset
        phase_tag = "R1";
        chk("R1", "bit_err_cnt", int'(bit_err_cnt), 0);
        chk("R1", "frm_err_cnt", int'(frm_err_cnt), 0);
        chk("R1", "err_seen", int'(err_seen), 0);
        chk("R1", "align_slip", int'(align_slip), 0);

        // R2: valid garbage before lock, and idle garbage, are ignored
        phase_tag = "R2";
        for (int i = 0; i < 6; i++) begin
            pl_valid = (i % 2 == 0); pl_data = 8'hA5 ^ 8'(i);
            step();
        end

        // R3: clean alternating frames, reload at every start
        phase_tag = "R3";
        for (int f = 0; f < 6; f++) send_frame(30, f[0], -1, 8'h00, 8'h00, -1);

        // R4: single and multi-bit errors
        phase_tag = "R4";
        send_frame(30, 0, 5, 8'h10, 8'h00, -1);
        send_frame(30, 1, 0, 8'hC3, 8'h00, -1);
        send_frame(30, 0, 29, 8'h81, 8'h00, -1);

        // R5: many errored bytes in one frame count as one frame
        phase_tag = "R5";
        send_frame(20, 1, -1, 8'h00, 8'h01, -1);
        send_frame(20, 0, -1, 8'h00, 8'h00, -1);

        // R8: parity repeats, checker follows the indicated seed
        phase_tag = "R8";
        send_frame(20, 0, -1, 8'h00, 8'h00, -1);
        send_frame(20, 1, -1, 8'h00, 8'h00, -1);
        send_frame(20, 1, 3, 8'h04, 8'h00, -1);

        // R7: clear alone, then clear coinciding with an error
        phase_tag = "R7";
        clear = 1; step();
        send_frame(20, 0, 4, 8'hFF, 8'h00, 4);
        send_frame(20, 1, 2, 8'h0F, 8'h00, 10);
        clear = 1; step();
        send_frame(20, 0, -1, 8'h00, 8'h00, -1);

        // R4 / R5: saturation of both counters
        phase_tag = "R5";
        for (int f = 0; f < MAXC + 20; f++) send_frame(2, f[0], 0, 8'h80, 8'h00, -1);
        phase_tag = "R4";
        send_frame(200, 1, -1, 8'h00, 8'hFF, -1);
        chk("R4", "bit_err_cnt saturated", int'(bit_err_cnt), MAXC);
        chk("R5", "frm_err_cnt saturated", int'(frm_err_cnt), MAXC);

        phase_tag = "R7";
        clear = 1; step();
        send_frame(20, 0, -1, 8'h00, 8'h00, -1);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule